// File: doc/BRIEF.md
# Memory Write Protection Unit

This block decides, every cycle, whether a byte write to a 2048-byte array may proceed and whether a write to the protection status register may proceed. It holds a small status register with four live bits: a write enable latch, two range-select bits and a pin-enable bit. It also takes an active-low hardware write-protect pin and the 11-bit address of the pending array write.

Array writes depend only on the latch and on the two range-select bits, which cover none, the upper quarter, the upper half or all of the array. Status writes depend on the latch and on the pin. The pin only counts when the pin-enable bit is set. A command decoder next to this block sends set and clear pulses for the latch, presents status-write requests, and signals the end of each write transaction. Both grant outputs are combinational and follow the current state and the current address and pin.

Top module: `mem_write_guard`

## Requirements
- R1: The range-select code `{rsel1,rsel0}` (status bits 3 and 2) selects the protected addresses: 00 protects none, 01 protects 600h–7FFh, 10 protects 400h–7FFh, and 11 protects 000h–7FFh.
- R2: While the latch is 0, `arr_grant_o` and `sr_grant_o` are both 0 for every address, every pin level and every range code.
- R3: While the latch is 1, `arr_grant_o` is 1 for an address outside the protected range and 0 for an address inside it.
- R4: While pin-enable (status bit 7) is 0, the level of `wp_n_i` has no effect on `sr_grant_o`.
- R5: `sr_grant_o` is 0 exactly when the latch is 1, pin-enable is 1 and `wp_n_i` is 0. In every other case where the latch is 1, it is 1.
- R6: `wp_n_i` and pin-enable have no effect on `arr_grant_o`.
- R7: A `wen_set_i` pulse sets the latch at the next clock edge. A `wen_clr_i` pulse or a `txn_end_i` pulse clears it at the next clock edge. A clear wins over a set in the same cycle.
- R8: A `sr_wr_req_i` cycle with `sr_grant_o`=1 loads range-select from data bits 3:2 and pin-enable from data bit 7 at the clock edge. A denied request changes nothing. Data bit 1 never changes the latch.
- R9: `sr_rdata_o` shows the latch on bit 1, rsel0 on bit 2, rsel1 on bit 3 and pin-enable on bit 7. Bits 0, 4, 5 and 6 read 0.
- R10: After reset, the latch, range-select and pin-enable are all 0, so `sr_rdata_o` is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wen_set_i | input | 1 | Pulse from the decoder: set the write enable latch |
| wen_clr_i | input | 1 | Pulse from the decoder: clear the write enable latch |
| txn_end_i | input | 1 | Pulse: a write or status-write transaction ended; clears the latch |
| sr_wr_req_i | input | 1 | Status register write request this cycle |
| sr_wr_data_i | input | 8 | Status register write data |
| wp_n_i | input | 1 | Active-low hardware write-protect pin |
| arr_addr_i | input | 11 | Address of the pending array write |
| arr_grant_o | output | 1 | 1 when the array write at `arr_addr_i` is allowed |
| sr_grant_o | output | 1 | 1 when a status write is allowed |
| sr_rdata_o | output | 8 | Status register read value |

## Verification
For each of the four range codes, the array grant is probed with the latch set at addresses on both sides of the quarter and half boundaries (000h, 3FFh, 400h, 5FFh, 600h, 7FFh). This separates an off-by-one boundary from a swapped code, and the same sweep with the latch clear shows the latch veto. The status grant is tried at both pin levels with pin-enable set and with pin-enable clear, while the array grant is watched at the same time. This separates the pin's proper effect from any leak into array protection. Status writes with and without a grant, and set and clear pulses that collide in one cycle, show that a denied write changes nothing and that a clear wins.

// File: rtl/guard_pkg.sv
package guard_pkg;
    localparam int SR_W     = 8;
    localparam int SR_WEL   = 1;
    localparam int SR_RSEL0 = 2;
    localparam int SR_RSEL1 = 3;
    localparam int SR_PINEN = 7;

    typedef struct packed {
        logic       wel;
        logic [1:0] rsel;
        logic       pinen;
    } guard_state_t;
endpackage

// File: rtl/guard_range.sv
module guard_range #(
    parameter int ADDR_W = 11
) (
    input  logic [1:0]        rsel_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_o
);
    localparam int TOP = ADDR_W - 1;

    always_comb begin
        unique case (rsel_i)
            2'b00: hit_o = 1'b0;
            2'b01: hit_o = addr_i[TOP] & addr_i[TOP-1];
            2'b10: hit_o = addr_i[TOP];
            default: hit_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/guard_regs.sv
module guard_regs
    import guard_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_i,
    input  logic         clr_i,
    input  logic         load_i,
    input  logic [1:0]   rsel_i,
    input  logic         pinen_i,
    output guard_state_t state_o
);
    guard_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.rsel  = rsel_i;
            st_d.pinen = pinen_i;
        end
        if (clr_i) begin
            st_d.wel = 1'b0;
        end else if (set_i) begin
            st_d.wel = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign state_o = st_q;
endmodule

// File: rtl/mem_write_guard.sv
module mem_write_guard
    import guard_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wen_set_i,
    input  logic              wen_clr_i,
    input  logic              txn_end_i,
    input  logic              sr_wr_req_i,
    input  logic [SR_W-1:0]   sr_wr_data_i,
    input  logic              wp_n_i,
    input  logic [ADDR_W-1:0] arr_addr_i,
    output logic              arr_grant_o,
    output logic              sr_grant_o,
    output logic [SR_W-1:0]   sr_rdata_o
);
    guard_state_t st;
    logic         in_range;
    logic         sr_lock;
    logic         unused_wdata;

    assign unused_wdata = ^{sr_wr_data_i[6:4], sr_wr_data_i[1:0]};

    guard_range #(.ADDR_W(ADDR_W)) u_range (
        .rsel_i (st.rsel),
        .addr_i (arr_addr_i),
        .hit_o  (in_range)
    );

    guard_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (wen_set_i),
        .clr_i   (wen_clr_i | txn_end_i),
        .load_i  (sr_wr_req_i & sr_grant_o),
        .rsel_i  ({sr_wr_data_i[SR_RSEL1], sr_wr_data_i[SR_RSEL0]}),
        .pinen_i (sr_wr_data_i[SR_PINEN]),
        .state_o (st)
    );

    // Pin only counts when its enable bit is set.
    assign sr_lock     = st.pinen & ~wp_n_i;
    assign arr_grant_o = st.wel & ~in_range;
    assign sr_grant_o  = st.wel & ~sr_lock;

    always_comb begin
        sr_rdata_o            = '0;
        sr_rdata_o[SR_WEL]    = st.wel;
        sr_rdata_o[SR_RSEL0]  = st.rsel[0];
        sr_rdata_o[SR_RSEL1]  = st.rsel[1];
        sr_rdata_o[SR_PINEN]  = st.pinen;
    end
endmodule

// File: rtl/guard_chk.sv
module guard_chk #(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wen_set_i,
    input logic              wen_clr_i,
    input logic              txn_end_i,
    input logic              sr_wr_req_i,
    input logic              wp_n_i,
    input logic [ADDR_W-1:0] arr_addr_i,
    input logic              arr_grant_o,
    input logic              sr_grant_o,
    input logic [7:0]        sr_rdata_o
);
    logic       wel, pinen;
    logic [1:0] rsel;
    assign wel   = sr_rdata_o[1];
    assign rsel  = sr_rdata_o[3:2];
    assign pinen = sr_rdata_o[7];

    p_all_locked_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rsel == 2'b11) |-> !arr_grant_o);
    p_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wel && rsel == 2'b00) |-> arr_grant_o);
    p_half_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsel == 2'b10 && arr_addr_i[ADDR_W-1]) |-> !arr_grant_o);
    p_latch_veto_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wel |-> (!arr_grant_o && !sr_grant_o));
    p_pin_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wel && !pinen) |-> sr_grant_o);
    p_sr_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wel && pinen) |-> (sr_grant_o == wp_n_i));
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wen_clr_i || txn_end_i) |=> !wel);
    p_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wen_set_i && !wen_clr_i && !txn_end_i) |=> wel);
    p_denied_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_wr_req_i && !sr_grant_o) |=> ($stable(rsel) && $stable(pinen)));
    p_zero_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_rdata_o[6:4] == 3'b000 && sr_rdata_o[0] == 1'b0));
endmodule

bind mem_write_guard guard_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wen_set_i   (wen_set_i),
    .wen_clr_i   (wen_clr_i),
    .txn_end_i   (txn_end_i),
    .sr_wr_req_i (sr_wr_req_i),
    .wp_n_i      (wp_n_i),
    .arr_addr_i  (arr_addr_i),
    .arr_grant_o (arr_grant_o),
    .sr_grant_o  (sr_grant_o),
    .sr_rdata_o  (sr_rdata_o)
);

// File: tb/mem_write_guard_tb.sv
`timescale 1ns/1ps
module mem_write_guard_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wen_set_i = 1'b0, wen_clr_i = 1'b0, txn_end_i = 1'b0;
    logic        sr_wr_req_i = 1'b0;
    logic [7:0]  sr_wr_data_i = 8'h00;
    logic        wp_n_i = 1'b1;
    logic [10:0] arr_addr_i = '0;
    logic        arr_grant_o, sr_grant_o;
    logic [7:0]  sr_rdata_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    mem_write_guard u_dut (
        .clk(clk), .rst_n(rst_n),
        .wen_set_i(wen_set_i), .wen_clr_i(wen_clr_i), .txn_end_i(txn_end_i),
        .sr_wr_req_i(sr_wr_req_i), .sr_wr_data_i(sr_wr_data_i),
        .wp_n_i(wp_n_i), .arr_addr_i(arr_addr_i),
        .arr_grant_o(arr_grant_o), .sr_grant_o(sr_grant_o), .sr_rdata_o(sr_rdata_o)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            fails = fails + 1;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic prot(input logic [1:0] rs, input logic [10:0] a);
        case (rs)
            2'b00: prot = 1'b0;
            2'b01: prot = (a >= 11'h600);
            2'b10: prot = (a >= 11'h400);
            default: prot = 1'b1;
        endcase
    endfunction

    task automatic pulse_set();
        @(negedge clk) wen_set_i = 1'b1;
        @(negedge clk) wen_set_i = 1'b0;
    endtask
    task automatic pulse_clr();
        @(negedge clk) wen_clr_i = 1'b1;
        @(negedge clk) wen_clr_i = 1'b0;
    endtask
    task automatic pulse_end();
        @(negedge clk) txn_end_i = 1'b1;
        @(negedge clk) txn_end_i = 1'b0;
    endtask
    task automatic sr_write(input logic [7:0] d);
        @(negedge clk) begin sr_wr_req_i = 1'b1; sr_wr_data_i = d; end
        @(negedge clk) sr_wr_req_i = 1'b0;
    endtask
    task automatic program_sr(input logic [7:0] d);
        pulse_set();
        sr_write(d);
        pulse_end();
    endtask

    task automatic t_reset();
        #1;
        check("R10 reset readback", sr_rdata_o, 8'h00);
        check("R2 array grant after reset", arr_grant_o, 1'b0);
        check("R2 status grant after reset", sr_grant_o, 1'b0);
    endtask

    task automatic t_latch();
        pulse_set();
        check("R7 set", sr_rdata_o[1], 1'b1);
        pulse_clr();
        check("R7 clear cmd", sr_rdata_o[1], 1'b0);
        pulse_set();
        pulse_end();
        check("R7 txn end clears", sr_rdata_o[1], 1'b0);
        @(negedge clk) begin wen_set_i = 1'b1; wen_clr_i = 1'b1; end
        @(negedge clk) begin wen_set_i = 1'b0; wen_clr_i = 1'b0; end
        check("R7 clear wins over set", sr_rdata_o[1], 1'b0);
    endtask

    task automatic t_ranges();
        logic [10:0] probes [6] = '{11'h000, 11'h3FF, 11'h400, 11'h5FF, 11'h600, 11'h7FF};
        for (int c = 0; c < 4; c++) begin
            program_sr({4'b0000, c[1:0], 2'b00});
            check("R9 range readback", sr_rdata_o, {4'b0000, c[1:0], 2'b00});
            for (int p = 0; p < 6; p++) begin
                arr_addr_i = probes[p]; #1;
                check("R2 latch clear denies array", arr_grant_o, 1'b0);
            end
            pulse_set();
            for (int p = 0; p < 6; p++) begin
                arr_addr_i = probes[p]; #1;
                check("R1 R3 range grant", arr_grant_o, !prot(c[1:0], probes[p]));
            end
            pulse_end();
        end
    endtask

    task automatic t_pin();
        wp_n_i = 1'b1;
        program_sr(8'h84);
        check("R8 granted write loads", sr_rdata_o, 8'h84);
        pulse_set();
        @(negedge clk) wp_n_i = 1'b0; #1;
        check("R5 locked by pin", sr_grant_o, 1'b0);
        arr_addr_i = 11'h000; #1;
        check("R6 pin low array low addr", arr_grant_o, 1'b1);
        arr_addr_i = 11'h600; #1;
        check("R6 pin low array high addr", arr_grant_o, 1'b0);
        sr_write(8'h00);
        check("R8 denied write unchanged", sr_rdata_o, 8'h86);
        wp_n_i = 1'b1; #1;
        check("R5 pin high grants", sr_grant_o, 1'b1);
        arr_addr_i = 11'h000; #1;
        check("R6 pin high array low addr", arr_grant_o, 1'b1);
        sr_write(8'h00);
        check("R8 write clears pinen", sr_rdata_o, 8'h02);
        wp_n_i = 1'b0; #1;
        check("R4 pin ignored when disabled", sr_grant_o, 1'b1);
        sr_write(8'h08);
        check("R4 write goes through pin low", sr_rdata_o, 8'h0A);
        pulse_end();
        check("R2 status denied after end", sr_grant_o, 1'b0);
        wp_n_i = 1'b1;
    endtask

    task automatic t_layout();
        pulse_set();
        sr_write(8'hFF);
        check("R9 layout all ones", sr_rdata_o, 8'h8E);
        sr_write(8'h00);
        check("R8 data bit1 does not clear latch", sr_rdata_o, 8'h02);
        pulse_end();
        @(negedge clk) begin sr_wr_req_i = 1'b1; sr_wr_data_i = 8'hFF; end
        @(negedge clk) sr_wr_req_i = 1'b0;
        check("R8 write with latch clear ignored", sr_rdata_o, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_latch();
        t_ranges();
        t_pin();
        t_layout();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule